// File: doc/BRIEF.md
# Real-Time Clock Register Block with Alarm

This block is the register side of a real-time clock. It exposes a 32-bit memory-mapped register set: a control word, a read-only status word, a free-running seconds counter, an alarm compare value, a watchdog timeout value and two persistent configuration words. Time advances through a one-cycle `tick` pulse that stands in for the slow-domain one-second strobe. The crystal, power domains and slow-domain copy timing are all left outside the block.

Every writable register sits at a 16-byte aligned slot. The slot base replaces the register. Offset +0x4 ORs the written data in. Offset +0x8 clears the bits that are 1 in the data. Software can therefore change single bits without a read-modify-write. The alarm has two gates: an arm bit in persistent word 0, which lets the comparison raise a sticky flag, and an interrupt enable in the control word, which lets that flag reach the interrupt pin. The flag stays set until software writes a 1 to its position through the control clear alias.

Reads are combinational from the address. The low nibble of the address is ignored on reads, so all three aliases of a register return its value.

Top module: `rtc_regblk`

## Requirements
- R1: After reset, control, seconds, alarm, watchdog, persistent 0 and persistent 1 all read 0, and `irq_alarm` is 0.
- R2: A write to a slot base (address low nibble 0x0) replaces the register. Only implemented bits are stored: control keeps mask 0x17, persistent 0 keeps mask 0xF7, persistent 1 keeps only bit 31, and seconds, alarm and watchdog keep all 32 bits.
- R3: A write at slot base + 0x4 ORs the data into the register.
- R4: A write at slot base + 0x8 clears every register bit that is 1 in the data. A write at slot base + 0xC changes nothing.
- R5: Status at 0x10 is read-only. Bit 31 always reads 1, bit 28 reflects `strap_xtal_32000`, bit 27 reflects `strap_xtal_32768`, and all other bits read 0. Writes to it change nothing.
- R6: Seconds (0x30) increases by one on each `tick` and wraps from 0xFFFFFFFF to 0. When a software write to seconds lands in the same cycle as a tick, the write wins and that tick is lost.
- R7: Control bit 2, the alarm flag, is set on the tick whose new seconds value equals the alarm register (0x40), but only if persistent 0 (0x60) bit 2 is 1. Once set, the flag stays set across later ticks.
- R8: Writing 0x4 to control clear (0x08) clears the alarm flag. If an alarm match happens in the same cycle, the flag ends up set.
- R9: `irq_alarm` is 1 exactly when control bit 2 and control bit 0 are both 1.
- R10: When an alarm match sets the flag while persistent 0 bit 1 is 1, persistent 0 bit 7 is set at the same time. Without bit 1, bit 7 is left alone.
- R11: The slot map is control 0x00, status 0x10, seconds 0x30, alarm 0x40, watchdog 0x50, persistent 0 0x60 and persistent 1 0x70. Slot 0x20 and slots at 0x80 and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle pulse per second |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address: bits 7:4 select the slot, bits 3:0 select the alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| strap_xtal_32000 | input | 1 | Strap: a 32000 Hz crystal is fitted |
| strap_xtal_32768 | input | 1 | Strap: a 32768 Hz crystal is fitted |
| irq_alarm | output | 1 | Alarm interrupt request |

## Verification
The bench targets the collisions.

- A software write to seconds in the same cycle as a tick. A design that let the tick through would read one more than the written value.
- A flag clear in the same cycle as an alarm match. A design that favoured the clear would silently lose an alarm.
- Alarm matching with the arm bit off, and flag persistence after the seconds value moves past the alarm. A design that compared the old seconds value, or did not hold the flag, would raise the flag one tick late or drop it again.
- The alias offsets, reserved bits and holes in the map. A design with a wrong mask or decode would leak bits into readback or corrupt a neighbouring register.

// File: rtl/rtcblk_pkg.sv
package rtcblk_pkg;
  localparam int DATA_W = 32;

  // slot indices (address bits 7:4)
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_SEC  = 3;
  localparam int IDX_ALRM = 4;
  localparam int IDX_WDOG = 5;
  localparam int IDX_PER0 = 6;
  localparam int IDX_PER1 = 7;

  // writable slots, in decode order
  localparam int NUM_WR = 6;
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_SEC  = 1;
  localparam int SLOT_ALRM = 2;
  localparam int SLOT_WDOG = 3;
  localparam int SLOT_PER0 = 4;
  localparam int SLOT_PER1 = 5;
  localparam int WR_IDX [NUM_WR] = '{IDX_CTRL, IDX_SEC, IDX_ALRM, IDX_WDOG, IDX_PER0, IDX_PER1};

  // alias selectors (address bits 3:0)
  localparam logic [3:0] SUB_LOAD = 4'h0;
  localparam logic [3:0] SUB_SET  = 4'h4;
  localparam logic [3:0] SUB_CLR  = 4'h8;

  // control bits
  localparam int CTL_ALM_IE   = 0;
  localparam int CTL_MS_IE    = 1;
  localparam int CTL_ALM_FLAG = 2;
  localparam int CTL_WDOG_EN  = 4;
  // persistent 0 bits
  localparam int P0_CLKSRC    = 0;
  localparam int P0_WAKE_EN   = 1;
  localparam int P0_ALM_ARM   = 2;
  localparam int P0_FAST_PWR  = 4;
  localparam int P0_SLOW_PWR  = 5;
  localparam int P0_F32000    = 6;
  localparam int P0_WAKE_FLAG = 7;
  // persistent 1 bits
  localparam int P1_FORCE_UPD = 31;
  // status bits
  localparam int ST_PRESENT   = 31;
  localparam int ST_X32000    = 28;
  localparam int ST_X32768    = 27;

  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTL_ALM_IE) | (1 << CTL_MS_IE) |
                                                    (1 << CTL_ALM_FLAG) | (1 << CTL_WDOG_EN));
  localparam logic [DATA_W-1:0] PER0_MASK = DATA_W'((1 << P0_CLKSRC) | (1 << P0_WAKE_EN) |
                                                    (1 << P0_ALM_ARM) | (1 << P0_FAST_PWR) |
                                                    (1 << P0_SLOW_PWR) | (1 << P0_F32000) |
                                                    (1 << P0_WAKE_FLAG));
  localparam logic [DATA_W-1:0] PER1_MASK = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] FULL_MASK = {DATA_W{1'b1}};

  typedef enum logic [1:0] {WK_NONE, WK_LOAD, WK_SET, WK_CLR} wr_kind_e;

  function automatic logic [DATA_W-1:0] apply_write(input logic [DATA_W-1:0] old_v,
                                                    input logic [DATA_W-1:0] data,
                                                    input wr_kind_e kind);
    logic [DATA_W-1:0] res;
    unique case (kind)
      WK_LOAD: res = data;
      WK_SET:  res = old_v | data;
      WK_CLR:  res = old_v & ~data;
      default: res = old_v;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/rtcblk_decode.sv
module rtcblk_decode
  import rtcblk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  output logic [NUM_WR-1:0]        sel,
  output wr_kind_e                 kind
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;
  logic             kind_ok;

  assign idx = addr[ADDR_W-1:4];

  always_comb begin
    unique case (addr[3:0])
      SUB_LOAD: kind = WK_LOAD;
      SUB_SET:  kind = WK_SET;
      SUB_CLR:  kind = WK_CLR;
      default:  kind = WK_NONE;
    endcase
  end

  assign kind_ok = (kind != WK_NONE);

  for (genvar g = 0; g < NUM_WR; g++) begin : g_sel
    assign sel[g] = wr && kind_ok && (idx == IDX_W'(WR_IDX[g]));
  end
endmodule

// File: rtl/rtcblk_reg.sv
module rtcblk_reg
  import rtcblk_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = {DATA_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  wr_kind_e          kind,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] q
);
  logic              en;
  logic [DATA_W-1:0] d;

  always_comb begin
    en = sel || (|hw_set);
    d  = q;
    if (sel) d = apply_write(q, wdata, kind);
    d = (d | hw_set) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/rtcblk_seconds.sv
module rtcblk_seconds
  import rtcblk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  wr_kind_e          kind,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic [DATA_W-1:0] alarm,
  input  logic              arm,
  output logic [DATA_W-1:0] q,
  output logic              fire
);
  logic              en;
  logic [DATA_W-1:0] inc;
  logic [DATA_W-1:0] d;

  assign inc = q + DATA_W'(1);

  always_comb begin
    en = sel || tick;
    d  = q;
    if (sel)       d = apply_write(q, wdata, kind);
    else if (tick) d = inc;
  end

  // match is judged on the value the tick produces; a write that cycle suppresses it
  assign fire = tick && !sel && arm && (inc == alarm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/rtc_regblk.sv
module rtc_regblk
  import rtcblk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              strap_xtal_32000,
  input  logic              strap_xtal_32768,
  output logic              irq_alarm
);
  localparam int IDX_W = ADDR_W - 4;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [NUM_WR-1:0] sel;
  wr_kind_e          kind;
  logic              fire;
  logic [DATA_W-1:0] ctrl_q, sec_q, alrm_q, wdog_q, per0_q, per1_q;
  logic [DATA_W-1:0] stat_v;
  logic [DATA_W-1:0] ctrl_hw, per0_hw;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rtcblk_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr   (bus_wr),
    .addr (bus_addr),
    .sel  (sel),
    .kind (kind)
  );

  rtcblk_seconds u_sec (
    .clk   (clk),
    .rst_n (rst_core_n),
    .sel   (sel[SLOT_SEC]),
    .kind  (kind),
    .wdata (bus_wdata),
    .tick  (tick),
    .alarm (alrm_q),
    .arm   (per0_q[P0_ALM_ARM]),
    .q     (sec_q),
    .fire  (fire)
  );

  always_comb begin
    ctrl_hw = '0;
    per0_hw = '0;
    ctrl_hw[CTL_ALM_FLAG] = fire;
    per0_hw[P0_WAKE_FLAG] = fire && per0_q[P0_WAKE_EN];
  end

  rtcblk_reg #(.MASK(CTRL_MASK)) u_ctrl (
    .clk (clk), .rst_n (rst_core_n), .sel (sel[SLOT_CTRL]), .kind (kind),
    .wdata (bus_wdata), .hw_set (ctrl_hw), .q (ctrl_q)
  );

  rtcblk_reg #(.MASK(FULL_MASK)) u_alrm (
    .clk (clk), .rst_n (rst_core_n), .sel (sel[SLOT_ALRM]), .kind (kind),
    .wdata (bus_wdata), .hw_set ('0), .q (alrm_q)
  );

  rtcblk_reg #(.MASK(FULL_MASK)) u_wdog (
    .clk (clk), .rst_n (rst_core_n), .sel (sel[SLOT_WDOG]), .kind (kind),
    .wdata (bus_wdata), .hw_set ('0), .q (wdog_q)
  );

  rtcblk_reg #(.MASK(PER0_MASK)) u_per0 (
    .clk (clk), .rst_n (rst_core_n), .sel (sel[SLOT_PER0]), .kind (kind),
    .wdata (bus_wdata), .hw_set (per0_hw), .q (per0_q)
  );

  rtcblk_reg #(.MASK(PER1_MASK)) u_per1 (
    .clk (clk), .rst_n (rst_core_n), .sel (sel[SLOT_PER1]), .kind (kind),
    .wdata (bus_wdata), .hw_set ('0), .q (per1_q)
  );

  always_comb begin
    stat_v = '0;
    stat_v[ST_PRESENT] = 1'b1;
    stat_v[ST_X32000]  = strap_xtal_32000;
    stat_v[ST_X32768]  = strap_xtal_32768;
  end

  always_comb begin
    unique case (bus_addr[ADDR_W-1:4])
      IDX_W'(IDX_CTRL): bus_rdata = ctrl_q;
      IDX_W'(IDX_STAT): bus_rdata = stat_v;
      IDX_W'(IDX_SEC):  bus_rdata = sec_q;
      IDX_W'(IDX_ALRM): bus_rdata = alrm_q;
      IDX_W'(IDX_WDOG): bus_rdata = wdog_q;
      IDX_W'(IDX_PER0): bus_rdata = per0_q;
      IDX_W'(IDX_PER1): bus_rdata = per1_q;
      default:          bus_rdata = '0;
    endcase
  end

  assign irq_alarm = ctrl_q[CTL_ALM_FLAG] && ctrl_q[CTL_ALM_IE];
endmodule

// File: rtl/rtcblk_chk.sv
module rtcblk_chk
  import rtcblk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_alarm,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] per0_q,
  input logic [DATA_W-1:0] sec_q,
  input logic [DATA_W-1:0] alrm_q
);
  localparam logic [ADDR_W-1:0] A_ALRM_SET = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_ALRM_CLR = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] A_CTRL_CLR = ADDR_W'(8'h08);

  assert_sec_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec_q) |-> $past(tick || bus_wr));

  assert_set_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == A_ALRM_SET) |-> ((alrm_q & $past(alrm_q)) == $past(alrm_q)));

  assert_clr_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == A_ALRM_CLR) |-> ((alrm_q & ~$past(alrm_q)) == '0));

  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[CTL_ALM_FLAG]) |-> $past(bus_wr || (tick && per0_q[P0_ALM_ARM])));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == A_CTRL_CLR && bus_wdata[CTL_ALM_FLAG] && !tick)
    |-> !ctrl_q[CTL_ALM_FLAG]);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_alarm) |-> $past(bus_wr || tick));
endmodule

bind rtc_regblk rtcblk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_alarm (irq_alarm),
  .ctrl_q    (ctrl_q),
  .per0_q    (per0_q),
  .sec_q     (sec_q),
  .alrm_q    (alrm_q)
);

// File: tb/test_rtc_regblk.sv
`timescale 1ns/100ps
module test_rtc_regblk;
  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        s32000, s32768;
  logic        irq_alarm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_ctrl, m_sec, m_alrm, m_wdog, m_p0, m_p1;

  rtc_regblk #(.ADDR_W(8)) i_rtc_regblk (
    .clk (clk), .rst_n (rst_n), .tick (tick), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .strap_xtal_32000 (s32000), .strap_xtal_32768 (s32768), .irq_alarm (irq_alarm)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] f_apply(input logic [31:0] old_v, input logic [31:0] d,
                                          input logic [3:0] sub);
    case (sub)
      4'h0: return d;
      4'h4: return old_v | d;
      4'h8: return old_v & ~d;
      default: return old_v;
    endcase
  endfunction

  function automatic logic [31:0] f_stat();
    return {1'b1, 2'b00, s32000, s32768, 27'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic tk);
    logic [31:0] o_ctrl, o_p0, o_sec, o_alrm;
    logic [3:0]  slot, sub;
    logic        valid, sec_w, hit;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk;
    @(posedge clk);
    o_ctrl = m_ctrl; o_p0 = m_p0; o_sec = m_sec; o_alrm = m_alrm;
    slot = a[7:4]; sub = a[3:0];
    valid = wr && (sub == 4'h0 || sub == 4'h4 || sub == 4'h8);
    sec_w = valid && slot == 4'd3;
    hit = tk && !sec_w && o_p0[2] && (o_sec + 32'd1 == o_alrm);
    if (sec_w) m_sec = f_apply(o_sec, d, sub);
    else if (tk) m_sec = o_sec + 32'd1;
    if (valid && slot == 4'd0) m_ctrl = f_apply(o_ctrl, d, sub) & 32'h17;
    if (valid && slot == 4'd4) m_alrm = f_apply(o_alrm, d, sub);
    if (valid && slot == 4'd5) m_wdog = f_apply(m_wdog, d, sub);
    if (valid && slot == 4'd6) m_p0 = f_apply(o_p0, d, sub) & 32'hF7;
    if (valid && slot == 4'd7) m_p1 = f_apply(m_p1, d, sub) & 32'h8000_0000;
    if (hit) begin
      m_ctrl = m_ctrl | 32'h4;
      if (o_p0[1]) m_p0 = m_p0 | 32'h80;
    end
    #1;
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic check_all(input string tag);
    rd(tag, 8'h00, m_ctrl);
    rd(tag, 8'h10, f_stat());
    rd(tag, 8'h30, m_sec);
    rd(tag, 8'h44, m_alrm);
    rd(tag, 8'h58, m_wdog);
    rd(tag, 8'h60, m_p0);
    rd(tag, 8'h7C, m_p1);
    chk({tag, " irq"}, {31'd0, irq_alarm}, {31'd0, m_ctrl[2] & m_ctrl[0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    s32000 = 1'b1; s32768 = 1'b0;
    m_ctrl = '0; m_sec = '0; m_alrm = '0; m_wdog = '0; m_p0 = '0; m_p1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_all("R1");
    chk("R1 irq", {31'd0, irq_alarm}, 32'd0);

    // R5 status read-only and straps
    step(1, 8'h10, 32'hFFFF_FFFF, 0);
    step(1, 8'h14, 32'hFFFF_FFFF, 0);
    rd("R5", 8'h10, 32'h9000_0000);
    s32000 = 1'b0; s32768 = 1'b1;
    rd("R5", 8'h10, 32'h8800_0000);
    check_all("R5");

    // R2 base writes and masks; R9 irq from base write
    step(1, 8'h00, 32'hFFFF_FFFF, 0);
    rd("R2", 8'h00, 32'h0000_0017);
    chk("R9", {31'd0, irq_alarm}, 32'd1);
    step(1, 8'h00, 32'h0, 0);
    step(1, 8'h60, 32'hFFFF_FFFF, 0);
    rd("R2", 8'h60, 32'h0000_00F7);
    step(1, 8'h70, 32'hFFFF_FFFF, 0);
    rd("R2", 8'h70, 32'h8000_0000);
    step(1, 8'h50, 32'hA5A5_5A5A, 0);
    rd("R2", 8'h50, 32'hA5A5_5A5A);
    step(1, 8'h60, 32'h0, 0);
    step(1, 8'h78, 32'h8000_0000, 0);
    rd("R4", 8'h70, 32'h0);

    // R3 / R4 aliases
    step(1, 8'h40, 32'h0F0F_0000, 0);
    step(1, 8'h44, 32'h0000_00FF, 0);
    rd("R3", 8'h40, 32'h0F0F_00FF);
    step(1, 8'h48, 32'h0F00_0000, 0);
    rd("R4", 8'h40, 32'h000F_00FF);
    step(1, 8'h4C, 32'hFFFF_FFFF, 0);
    rd("R4", 8'h40, 32'h000F_00FF);

    // R11 holes
    step(1, 8'h20, 32'hFFFF_FFFF, 0);
    step(1, 8'h80, 32'hFFFF_FFFF, 0);
    step(1, 8'hF4, 32'hFFFF_FFFF, 0);
    rd("R11", 8'h20, 32'h0);
    rd("R11", 8'h80, 32'h0);
    check_all("R11");

    // R6 counting, wrap, collision
    step(1, 8'h30, 32'hFFFF_FFFE, 0);
    step(0, 8'h00, 32'h0, 1);
    rd("R6", 8'h30, 32'hFFFF_FFFF);
    step(0, 8'h00, 32'h0, 1);
    rd("R6", 8'h30, 32'h0);
    step(1, 8'h30, 32'h100, 1);
    rd("R6", 8'h30, 32'h100);

    // R7 alarm match
    step(1, 8'h40, 32'h105, 0);
    step(1, 8'h64, 32'h4, 0);
    step(1, 8'h04, 32'h1, 0);
    for (int i = 0; i < 4; i++) step(0, 8'h00, 32'h0, 1);
    rd("R7", 8'h00, 32'h1);
    chk("R9", {31'd0, irq_alarm}, 32'd0);
    step(0, 8'h00, 32'h0, 1);
    rd("R7", 8'h00, 32'h5);
    chk("R9", {31'd0, irq_alarm}, 32'd1);
    rd("R10", 8'h60, 32'h4);
    step(0, 8'h00, 32'h0, 1);
    step(0, 8'h00, 32'h0, 1);
    rd("R7", 8'h00, 32'h5);

    // R8 clear, then collision with wake enabled (R10)
    step(1, 8'h08, 32'h4, 0);
    rd("R8", 8'h00, 32'h1);
    chk("R8 irq", {31'd0, irq_alarm}, 32'd0);
    step(1, 8'h64, 32'h2, 0);
    step(1, 8'h30, 32'h200, 0);
    step(1, 8'h40, 32'h201, 0);
    step(1, 8'h08, 32'h4, 1);
    rd("R8", 8'h00, 32'h5);
    rd("R10", 8'h60, 32'h86);
    step(1, 8'h08, 32'h1, 0);
    chk("R9", {31'd0, irq_alarm}, 32'd0);

    // R7 disarmed: no flag on match
    step(1, 8'h08, 32'h4, 0);
    step(1, 8'h68, 32'h4, 0);
    step(1, 8'h30, 32'h300, 0);
    step(1, 8'h40, 32'h301, 0);
    step(0, 8'h00, 32'h0, 1);
    rd("R7", 8'h00, 32'h0);
    check_all("R7");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  slot;
      logic [3:0]  sub;
      logic [31:0] d;
      slot = 4'($urandom_range(0, 8));
      sub  = 4'($urandom_range(0, 3) * 4);
      d    = $urandom;
      if (slot == 4'd3 || slot == 4'd4) d = d & 32'h7;
      if (slot == 4'd6 && sub == 4'h0) d = d | 32'h4;
      step($urandom_range(0, 2) != 0, {slot, sub}, d, $urandom_range(0, 1) == 1);
      if (n % 8 == 0) check_all("R2 random");
      else rd("R6 random", 8'h30, m_sec);
      chk("R9 random", {31'd0, irq_alarm}, {31'd0, m_ctrl[2] & m_ctrl[0]});
    end
    check_all("R3 random");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule